// File: doc/BRIEF.md
# Serial Pad Configuration Chain

This block places one control cell beside each user I/O pad and links the cells into a single serial configuration chain. Every cell holds a 13-bit shift stage and a 13-bit active configuration word. On each shift tick every cell moves its bits up by one position and passes its top bit to the next cell. A separate load strobe then copies the shift stages of all cells into their active words at the same moment. The active word drives the pad's electrical control pins and decides whether the management side or the user side drives the pad.

The lowest-numbered cells are full bidirectional management cells: management output and output enable reach the pad on their own wires. The remaining cells are selectable cells. In management mode they loop the pad input back out as the pad output, and their output enable comes from the stored configuration. An active-low loader reset puts each cell back to its own default. Bidirectional cells reset to an output drive mode and the other cells reset to an input drive mode.

Top module: `pcc_chain`

## Requirements
- R1: While `ld_rst_n` is low at a clock edge, both registers of cell i take that cell's default. Cells with i < NUM_BIDIR take 13'h1806 (manage bit 1, drive-off bit 1, drive mode 3'b110). All other cells take 13'h1801 (manage bit 1, drive-off bit 1, drive mode 3'b001). Every other field is 0.
- R2: On a clock edge with `shift_en` high, each cell's shift stage moves left by one bit. Cell 0 takes `ser_in` into bit 0, and cell k takes bit 12 of cell k-1. `ser_out` is bit 12 of the last cell's shift stage.
- R3: After 13*NUM_PADS shifts, the first bit shifted in sits in bit 12 of the last cell and the last bit sits in bit 0 of cell 0, so the stream holds the last cell's word first, each word MSB first.
- R4: On a clock edge with `load_en` high, every cell copies into its active word the shift-stage value it held before that edge. Without `load_en` the active words and all pad control outputs stay unchanged, including while shifting.
- R5: The active word layout, bit 12 down to 0, is: manage, drive-off (active-low output enable), holdover, input disable, input buffer mode, analog enable, analog select, analog polarity, slow slew, trip select, drive mode[2:0]. Each field drives its own per-pad output.
- R6: When manage is 0, `pad_out` equals `user_out` and `pad_oe_n` equals `user_oe_n` for that pad.
- R7: When manage is 1 on a cell with i < NUM_BIDIR, `pad_out` equals `mgmt_out[i]` and `pad_oe_n` equals `mgmt_oe_n[i]`. The stored drive-off bit and the user inputs have no effect there.
- R8: When manage is 1 on a cell with i >= NUM_BIDIR, `pad_out` equals `pad_in` of that pad and `pad_oe_n` equals the stored drive-off bit. `user_out` and `user_oe_n` have no effect.
- R9: `mgmt_in` and `user_in` always equal `pad_in`, whoever owns the pad.
- R10: Loader reset takes priority over `shift_en` and `load_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial configuration clock shared by all cells |
| ld_rst_n | input | 1 | Synchronous active-low loader reset |
| shift_en | input | 1 | Shift tick for the whole chain |
| load_en | input | 1 | Copies shift stages into active words |
| ser_in | input | 1 | Serial data into cell 0 |
| ser_out | output | 1 | Serial data out of the last cell |
| mgmt_out | input | NUM_BIDIR | Management output for bidirectional cells |
| mgmt_oe_n | input | NUM_BIDIR | Management active-low output enable for bidirectional cells |
| mgmt_in | output | NUM_PADS | Pad input returned to the management side |
| user_out | input | NUM_PADS | User output per pad |
| user_oe_n | input | NUM_PADS | User active-low output enable per pad |
| user_in | output | NUM_PADS | Pad input returned to the user side |
| pad_in | input | NUM_PADS | Value seen at each pad |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe_n | output | NUM_PADS | Active-low output enable per pad |
| pad_dm | output | 3*NUM_PADS | Drive mode, 3 bits per pad, pad i at [3i+2:3i] |
| pad_inp_dis | output | NUM_PADS | Input disable per pad |
| pad_ib_sel | output | NUM_PADS | Input buffer mode select per pad |
| pad_vtrip | output | NUM_PADS | Trip point select per pad |
| pad_slow | output | NUM_PADS | Slow slew select per pad |
| pad_hold | output | NUM_PADS | Holdover per pad |
| pad_ana_en | output | NUM_PADS | Analog enable per pad |
| pad_ana_sel | output | NUM_PADS | Analog select per pad |
| pad_ana_pol | output | NUM_PADS | Analog polarity per pad |

## Verification
The hardest case to reach from the ports is a chain where neighbouring cells hold opposite ownership. Each ownership kind has to show up on both a bidirectional and a selectable cell, and that depends on the reversed bit order landing every word in the right cell. The stimulus builds each stream from the intended per-cell words: it emits the last cell's word first, MSB first, and alternates the manage bit between rounds. This puts every routing mode on both cell kinds. Shift and load in the same cycle, and a reset that coincides with both strobes, are driven on purpose to cover the priority rules.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int CFG_W = 13;

  typedef struct packed {
    logic       manage;
    logic       drv_off;
    logic       hold;
    logic       inp_dis;
    logic       ib_sel;
    logic       ana_en;
    logic       ana_sel;
    logic       ana_pol;
    logic       slow;
    logic       vtrip;
    logic [2:0] dm;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_DEF_BIDIR = pad_cfg_t'(13'h1806);
  localparam pad_cfg_t CFG_DEF_INPUT = pad_cfg_t'(13'h1801);
endpackage

// File: rtl/pcc_shift.sv
module pcc_shift
  import pcc_pkg::*;
#(
  parameter pad_cfg_t RST_CFG = CFG_DEF_INPUT
) (
  input  logic     clk,
  input  logic     ld_rst_n,
  input  logic     shift_en,
  input  logic     load_en,
  input  logic     ser_in,
  output logic     ser_out,
  output pad_cfg_t cfg_q
);
  localparam int TOP = CFG_W - 1;

  logic [CFG_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!ld_rst_n) begin
      sh_q  <= RST_CFG;
      cfg_q <= RST_CFG;
    end else begin
      if (shift_en) sh_q <= {sh_q[TOP-1:0], ser_in};
      if (load_en)  cfg_q <= pad_cfg_t'(sh_q);
    end
  end

  assign ser_out = sh_q[TOP];

  // R4: active word holds without a load strobe
  p_hold_r4: assert property (@(posedge clk) disable iff (!ld_rst_n)
    !load_en |=> $stable(cfg_q));
  // R4: load copies the pre-edge shift stage
  p_load_r4: assert property (@(posedge clk) disable iff (!ld_rst_n)
    load_en |=> (cfg_q == pad_cfg_t'($past(sh_q))));
  // R2: new serial bit enters at the bottom
  p_shift_r2: assert property (@(posedge clk) disable iff (!ld_rst_n)
    shift_en |=> (sh_q[0] == $past(ser_in)));
  // R2: no tick, no movement
  p_still_r2: assert property (@(posedge clk) disable iff (!ld_rst_n)
    !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/pcc_route.sv
module pcc_route #(
  parameter bit FULL_BIDIR = 1'b0
) (
  input  logic manage,
  input  logic drv_off,
  input  logic mgmt_out,
  input  logic mgmt_oe_n,
  input  logic user_out,
  input  logic user_oe_n,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe_n,
  output logic mgmt_in,
  output logic user_in
);
  logic m_oe_n;

  generate
    if (FULL_BIDIR) begin : g_full
      assign m_oe_n = mgmt_oe_n;
    end else begin : g_sel
      // management enable is tied inactive here, so the stored bit rules
      assign m_oe_n = drv_off & mgmt_oe_n;
    end
  endgenerate

  always_comb begin
    if (manage) begin
      pad_out  = mgmt_out;
      pad_oe_n = m_oe_n;
    end else begin
      pad_out  = user_out;
      pad_oe_n = user_oe_n;
    end
  end

  assign mgmt_in = pad_in;
  assign user_in = pad_in;
endmodule

// File: rtl/pcc_cell.sv
module pcc_cell
  import pcc_pkg::*;
#(
  parameter bit       FULL_BIDIR = 1'b0,
  parameter pad_cfg_t RST_CFG    = CFG_DEF_INPUT
) (
  input  logic       clk,
  input  logic       ld_rst_n,
  input  logic       shift_en,
  input  logic       load_en,
  input  logic       ser_in,
  output logic       ser_out,
  input  logic       mgmt_out,
  input  logic       mgmt_oe_n,
  output logic       mgmt_in,
  input  logic       user_out,
  input  logic       user_oe_n,
  output logic       user_in,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe_n,
  output logic [2:0] pad_dm,
  output logic       pad_inp_dis,
  output logic       pad_ib_sel,
  output logic       pad_vtrip,
  output logic       pad_slow,
  output logic       pad_hold,
  output logic       pad_ana_en,
  output logic       pad_ana_sel,
  output logic       pad_ana_pol
);
  pad_cfg_t cfg;

  pcc_shift #(.RST_CFG(RST_CFG)) u_shift (
    .clk      (clk),
    .ld_rst_n (ld_rst_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .cfg_q    (cfg)
  );

  pcc_route #(.FULL_BIDIR(FULL_BIDIR)) u_route (
    .manage    (cfg.manage),
    .drv_off   (cfg.drv_off),
    .mgmt_out  (mgmt_out),
    .mgmt_oe_n (mgmt_oe_n),
    .user_out  (user_out),
    .user_oe_n (user_oe_n),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe_n  (pad_oe_n),
    .mgmt_in   (mgmt_in),
    .user_in   (user_in)
  );

  assign pad_dm      = cfg.dm;
  assign pad_inp_dis = cfg.inp_dis;
  assign pad_ib_sel  = cfg.ib_sel;
  assign pad_vtrip   = cfg.vtrip;
  assign pad_slow    = cfg.slow;
  assign pad_hold    = cfg.hold;
  assign pad_ana_en  = cfg.ana_en;
  assign pad_ana_sel = cfg.ana_sel;
  assign pad_ana_pol = cfg.ana_pol;

  // R6: user side owns the pad when the manage bit is clear
  p_user_own_r6: assert property (@(posedge clk) disable iff (!ld_rst_n)
    !cfg.manage |-> (pad_out == user_out && pad_oe_n == user_oe_n));
  // R9: pad input reaches both sides
  p_input_back_r9: assert property (@(posedge clk) disable iff (!ld_rst_n)
    (mgmt_in == pad_in) && (user_in == pad_in));
endmodule

// File: rtl/pcc_chain.sv
module pcc_chain
  import pcc_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int NUM_BIDIR = 2
) (
  input  logic                  clk,
  input  logic                  ld_rst_n,
  input  logic                  shift_en,
  input  logic                  load_en,
  input  logic                  ser_in,
  output logic                  ser_out,
  input  logic [NUM_BIDIR-1:0]  mgmt_out,
  input  logic [NUM_BIDIR-1:0]  mgmt_oe_n,
  output logic [NUM_PADS-1:0]   mgmt_in,
  input  logic [NUM_PADS-1:0]   user_out,
  input  logic [NUM_PADS-1:0]   user_oe_n,
  output logic [NUM_PADS-1:0]   user_in,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oe_n,
  output logic [3*NUM_PADS-1:0] pad_dm,
  output logic [NUM_PADS-1:0]   pad_inp_dis,
  output logic [NUM_PADS-1:0]   pad_ib_sel,
  output logic [NUM_PADS-1:0]   pad_vtrip,
  output logic [NUM_PADS-1:0]   pad_slow,
  output logic [NUM_PADS-1:0]   pad_hold,
  output logic [NUM_PADS-1:0]   pad_ana_en,
  output logic [NUM_PADS-1:0]   pad_ana_sel,
  output logic [NUM_PADS-1:0]   pad_ana_pol
);
  localparam int LINKS = NUM_PADS + 1;

  logic [LINKS-1:0] link;
  assign link[0] = ser_in;
  assign ser_out = link[NUM_PADS];

  generate
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_cell
      logic m_out, m_oe_n;
      if (i < NUM_BIDIR) begin : g_bidir
        assign m_out  = mgmt_out[i];
        assign m_oe_n = mgmt_oe_n[i];
      end else begin : g_loop
        assign m_out  = pad_in[i];
        assign m_oe_n = 1'b1;
      end

      pcc_cell #(
        .FULL_BIDIR (i < NUM_BIDIR),
        .RST_CFG    ((i < NUM_BIDIR) ? CFG_DEF_BIDIR : CFG_DEF_INPUT)
      ) u_cell (
        .clk         (clk),
        .ld_rst_n    (ld_rst_n),
        .shift_en    (shift_en),
        .load_en     (load_en),
        .ser_in      (link[i]),
        .ser_out     (link[i+1]),
        .mgmt_out    (m_out),
        .mgmt_oe_n   (m_oe_n),
        .mgmt_in     (mgmt_in[i]),
        .user_out    (user_out[i]),
        .user_oe_n   (user_oe_n[i]),
        .user_in     (user_in[i]),
        .pad_in      (pad_in[i]),
        .pad_out     (pad_out[i]),
        .pad_oe_n    (pad_oe_n[i]),
        .pad_dm      (pad_dm[3*i +: 3]),
        .pad_inp_dis (pad_inp_dis[i]),
        .pad_ib_sel  (pad_ib_sel[i]),
        .pad_vtrip   (pad_vtrip[i]),
        .pad_slow    (pad_slow[i]),
        .pad_hold    (pad_hold[i]),
        .pad_ana_en  (pad_ana_en[i]),
        .pad_ana_sel (pad_ana_sel[i]),
        .pad_ana_pol (pad_ana_pol[i])
      );
    end
  endgenerate

  // R10: reset beats both strobes; the serial output shows the default top bit
  p_reset_prio_r10: assert property (@(posedge clk)
    !ld_rst_n |=> (ser_out == 1'b1));
endmodule

// File: tb/pcc_chain_bench.sv
`timescale 1ns/1ps
module pcc_chain_bench;
  localparam int NP = 4;
  localparam int NB = 2;
  localparam int W  = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ld_rst_n, shift_en, load_en, ser_in, ser_out;
  logic [NB-1:0] mgmt_out, mgmt_oe_n;
  logic [NP-1:0] mgmt_in, user_out, user_oe_n, user_in, pad_in, pad_out, pad_oe_n;
  logic [3*NP-1:0] pad_dm;
  logic [NP-1:0] pad_inp_dis, pad_ib_sel, pad_vtrip, pad_slow, pad_hold;
  logic [NP-1:0] pad_ana_en, pad_ana_sel, pad_ana_pol;

  pcc_chain #(.NUM_PADS(NP), .NUM_BIDIR(NB)) u_pcc_chain (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] m_sh [NP];
  logic [W-1:0] m_cfg[NP];

  task automatic chk(input bit ok, input string tag, input int pad,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s pad %0d: actual %h expected %h", tag, pad, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dflt(input int i);
    return (i < NB) ? 13'h1806 : 13'h1801;
  endfunction

  function automatic logic [10:0] ctrl_of(input int i);
    return {pad_hold[i], pad_inp_dis[i], pad_ib_sel[i], pad_ana_en[i],
            pad_ana_sel[i], pad_ana_pol[i], pad_slow[i], pad_vtrip[i], pad_dm[3*i +: 3]};
  endfunction

  task automatic model_edge();
    logic [W-1:0] old [NP];
    for (int i = 0; i < NP; i++) old[i] = m_sh[i];
    if (!ld_rst_n) begin
      for (int i = 0; i < NP; i++) begin m_sh[i] = dflt(i); m_cfg[i] = dflt(i); end
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (load_en) m_cfg[i] = old[i];
        if (shift_en) m_sh[i] = {old[i][W-2:0], (i == 0) ? ser_in : old[i-1][W-1]};
      end
    end
  endtask

  task automatic compare(input string ctag);
    chk(ser_out === m_sh[NP-1][W-1], "R2 ser_out", NP-1, 16'(ser_out), 16'(m_sh[NP-1][W-1]));
    for (int i = 0; i < NP; i++) begin
      logic eo, eoe;
      chk(ctrl_of(i) === m_cfg[i][10:0], ctag, i, 16'(ctrl_of(i)), 16'(m_cfg[i][10:0]));
      if (!m_cfg[i][12]) begin eo = user_out[i]; eoe = user_oe_n[i]; end
      else if (i < NB)   begin eo = mgmt_out[i]; eoe = mgmt_oe_n[i]; end
      else               begin eo = pad_in[i];   eoe = m_cfg[i][11]; end
      chk({pad_out[i], pad_oe_n[i]} === {eo, eoe},
          !m_cfg[i][12] ? "R6 user route" : (i < NB) ? "R7 bidir route" : "R8 loop route",
          i, 16'({pad_out[i], pad_oe_n[i]}), 16'({eo, eoe}));
      chk(mgmt_in[i] === pad_in[i] && user_in[i] === pad_in[i], "R9 input return", i,
          16'({mgmt_in[i], user_in[i]}), 16'({pad_in[i], pad_in[i]}));
    end
  endtask

  task automatic step(input string ctag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(ctag);
    mgmt_out  = NB'($urandom);
    mgmt_oe_n = NB'($urandom);
    user_out  = NP'($urandom);
    user_oe_n = NP'($urandom);
    pad_in    = NP'($urandom);
  endtask

  task automatic run_round(input bit inv);
    logic [W-1:0] words [NP];
    logic [W*NP-1:0] stream;
    int n = 0;
    for (int k = 0; k < NP; k++) begin
      words[k] = W'($urandom);
      words[k][12] = inv ^ k[0];
    end
    for (int k = NP - 1; k >= 0; k--)
      for (int b = W - 1; b >= 0; b--) begin stream[n] = words[k][b]; n++; end
    shift_en = 1'b1;
    for (int t = 0; t < W * NP; t++) begin
      ser_in = stream[t];
      step("R4 no change while shifting");
    end
    shift_en = 1'b0;
    load_en  = 1'b1;
    step("R5 decode after load");
    load_en  = 1'b0;
    // R3: last cell holds the first word sent, cell 0 the last
    chk(ctrl_of(NP-1) === words[NP-1][10:0], "R3 order last cell", NP-1,
        16'(ctrl_of(NP-1)), 16'(words[NP-1][10:0]));
    chk(ctrl_of(0) === words[0][10:0], "R3 order first cell", 0,
        16'(ctrl_of(0)), 16'(words[0][10:0]));
    for (int t = 0; t < 8; t++) step("R5 steady");
  endtask

  initial begin
    ld_rst_n = 1'b0; shift_en = 1'b1; load_en = 1'b1; ser_in = 1'b0;
    mgmt_out = '0; mgmt_oe_n = '1; user_out = '0; user_oe_n = '1; pad_in = '0;
    for (int i = 0; i < NP; i++) begin m_sh[i] = '0; m_cfg[i] = '0; end
    step("R10 reset priority");
    step("R1 reset defaults");
    for (int i = 0; i < NP; i++)
      chk(ctrl_of(i) === dflt(i)[10:0], "R1 default", i, 16'(ctrl_of(i)), 16'(dflt(i)[10:0]));
    ld_rst_n = 1'b1; shift_en = 1'b0; load_en = 1'b0;
    for (int t = 0; t < 4; t++) step("R1 defaults hold");
    run_round(1'b0);
    run_round(1'b1);
    // R4: shift and load in the same cycle take the pre-edge value
    shift_en = 1'b1; load_en = 1'b1;
    for (int t = 0; t < 5; t++) begin ser_in = 1'($urandom); step("R4 shift with load"); end
    shift_en = 1'b0; load_en = 1'b0;
    run_round(1'b0);
    // R10: mid-run reset with both strobes high
    ld_rst_n = 1'b0; shift_en = 1'b1; load_en = 1'b1;
    step("R10 reset over strobes");
    ld_rst_n = 1'b1; shift_en = 1'b0; load_en = 1'b0;
    for (int i = 0; i < NP; i++)
      chk(ctrl_of(i) === dflt(i)[10:0], "R1 reset restore", i, 16'(ctrl_of(i)), 16'(dflt(i)[10:0]));
    for (int t = 0; t < 4; t++) step("R1 after restore");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule